// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Sequencer

This block is a priority interrupt controller for an 8-bit host that answers an interrupt by running a three-byte subroutine call taken from the data bus. Up to eight active-high request lines compete for service. Any line that is pending, not masked and not shut out by a line already in service raises the shared interrupt line toward the host. The host then gives three active-low acknowledge pulses. During the first pulse the block places the call opcode on its data output. During the second it places the low byte of the chosen line's service address, and during the third the high byte of that address.

The service address is a 16-bit base register plus the line number times a spacing of 4 or 8 bytes. A single control bit picks the spacing. Software writes the mask, base, spacing and end-of-interrupt registers through a small synchronous write port. Once a call sequence completes, the winning line is marked as in service. That line, and every line of lower priority, stays blocked until software clears the in-service bit with an end-of-interrupt write.

Top module: `irq_call_seq`

## Requirements
- R1: `int_o` is high exactly when the sequencer is idle and at least one request line is pending, unmasked and not blocked by an in-service line; it drops once the first acknowledge pulse has been registered.
- R2: Priority is fixed: line 0 wins over every other line, and line 7 loses to every other line.
- R3: While the first acknowledge pulse is low, `data_o` carries the call opcode 0xCD.
- R4: While the second acknowledge pulse is low, `data_o` carries bits 7:0 of the service address, which is base + line × step.
- R5: While the third acknowledge pulse is low, `data_o` carries bits 15:8 of the service address.
- R6: Bit 0 of the control register (write address 3) sets the step: 0 gives 4 bytes (the reset value) and 1 gives 8 bytes. Write address 1 holds base bits 7:0 and write address 2 holds base bits 15:8. The base resets to 0x0000.
- R7: The winning line is captured when the first acknowledge pulse falls. Request changes made later in the sequence do not change the address bytes.
- R8: When the third acknowledge pulse rises, the winner's in-service bit is set. While in-service bit k is set, lines k..7 cannot raise `int_o`, and lines below k can.
- R9: A write to address 4 clears every in-service bit whose data bit is 1.
- R10: `data_oe` is high only while `inta_n` is low. While `inta_n` is high, `data_o` reads 0x00.
- R11: A mask bit set to 1 at write address 0 (reset value 0xFF, all lines masked) removes that line from both `int_o` and priority resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Interrupt request lines, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| reg_wdata | input | 8 | Register write data |
| inta_n | input | 1 | Acknowledge strobe from host, active low |
| int_o | output | 1 | Interrupt request to host |
| data_o | output | 8 | Byte returned during acknowledge |
| data_oe | output | 1 | Output enable for `data_o` |

## Verification
`int_o` and `data_oe` are combinational from the request lines, the strobe and registered state. The bench therefore samples them on the falling clock edge after driving an input on a falling edge. A register write takes effect at the next rising edge and is checked on the falling edge after that. An acknowledge edge on `inta_n` is seen by one input register and moves the phase at the following rising edge, so each pulse is held low for two full cycles and each byte is sampled at the second falling edge. A completed sequence sets the in-service bit on the rising edge after `inta_n` returns high, and `int_o` is checked two cycles later.

// File: rtl/irq_call_pkg.sv
package irq_call_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OP   = 2'd1,
    PH_LO   = 2'd2,
    PH_HI   = 2'd3
  } ack_ph_t;

  localparam logic [7:0] CALL_OPCODE = 8'hCD;

  localparam logic [2:0] RA_MASK   = 3'd0;
  localparam logic [2:0] RA_BASE_L = 3'd1;
  localparam logic [2:0] RA_BASE_H = 3'd2;
  localparam logic [2:0] RA_CTRL   = 3'd3;
  localparam logic [2:0] RA_EOI    = 3'd4;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_call_pkg::*;
#(
  parameter int NLINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [7:0]        wdata,
  output logic [NLINES-1:0] mask_o,
  output logic [15:0]       base_o,
  output logic              wide_o,
  output logic              eoi_o,
  output logic [NLINES-1:0] eoi_bits_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_o <= '1;
      base_o <= '0;
      wide_o <= 1'b0;
    end else if (we) begin
      case (addr)
        RA_MASK:   mask_o       <= wdata[NLINES-1:0];
        RA_BASE_L: base_o[7:0]  <= wdata;
        RA_BASE_H: base_o[15:8] <= wdata;
        RA_CTRL:   wide_o       <= wdata[0];
        default:   ;
      endcase
    end
  end

  assign eoi_o      = we && (addr == RA_EOI);
  assign eoi_bits_o = wdata[NLINES-1:0];
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int NLINES = 8,
  localparam int IDX_W = $clog2(NLINES)
) (
  input  logic [NLINES-1:0] req,
  input  logic [NLINES-1:0] mask,
  input  logic [NLINES-1:0] isr,
  output logic              any_o,
  output logic [IDX_W-1:0]  win_o
);
  // Lowest index wins; an in-service bit shuts out itself and all higher indices.
  function automatic logic [IDX_W:0] pick(input logic [NLINES-1:0] cand,
                                          input logic [NLINES-1:0] busy);
    logic blocked;
    logic found;
    logic [IDX_W-1:0] idx;
    blocked = 1'b0;
    found   = 1'b0;
    idx     = '0;
    for (int i = 0; i < NLINES; i++) begin
      blocked = blocked | busy[i];
      if (!blocked && !found && cand[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
    return {found, idx};
  endfunction

  assign {any_o, win_o} = pick(req & ~mask, isr);
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import irq_call_pkg::*;
#(
  parameter int NLINES = 8,
  localparam int IDX_W = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inta_n,
  input  logic [IDX_W-1:0]  win_in,
  input  logic              eoi,
  input  logic [NLINES-1:0] eoi_bits,
  input  logic [15:0]       base,
  input  logic              wide,
  output ack_ph_t           ph_o,
  output logic              ack_fall_o,
  output logic              ack_rise_o,
  output logic [IDX_W-1:0]  win_q_o,
  output logic [NLINES-1:0] isr_o,
  output logic [7:0]        data_o,
  output logic              data_oe
);
  function automatic logic [15:0] svc_addr(input logic [15:0] b,
                                           input logic [IDX_W-1:0] n,
                                           input logic w);
    logic [15:0] off;
    off = 16'(n) << (w ? 2'd3 : 2'd2);
    return b + off;
  endfunction

  logic        inta_q;
  logic [15:0] addr;

  assign ack_fall_o = inta_q && !inta_n;
  assign ack_rise_o = !inta_q && inta_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inta_q  <= 1'b1;
      ph_o    <= PH_IDLE;
      win_q_o <= '0;
      isr_o   <= '0;
    end else begin
      inta_q <= inta_n;
      if (eoi) isr_o <= isr_o & ~eoi_bits;
      case (ph_o)
        PH_IDLE: if (ack_fall_o) begin
          ph_o    <= PH_OP;
          win_q_o <= win_in;
        end
        PH_OP: if (ack_rise_o) ph_o <= PH_LO;
        PH_LO: if (ack_rise_o) ph_o <= PH_HI;
        PH_HI: if (ack_rise_o) begin
          ph_o  <= PH_IDLE;
          isr_o <= (eoi ? (isr_o & ~eoi_bits) : isr_o) | (NLINES'(1) << win_q_o);
        end
        default: ph_o <= PH_IDLE;
      endcase
    end
  end

  assign addr    = svc_addr(base, win_q_o, wide);
  assign data_oe = !inta_n;

  always_comb begin
    data_o = 8'h00;
    if (!inta_n) begin
      case (ph_o)
        PH_LO:   data_o = addr[7:0];
        PH_HI:   data_o = addr[15:8];
        default: data_o = CALL_OPCODE;
      endcase
    end
  end

  a_r3_opcode_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_o == PH_OP && !inta_n) |-> (data_o == CALL_OPCODE));

  a_r7_winner_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_o != PH_IDLE) |=> (ph_o == PH_IDLE || $stable(win_q_o)));

  a_r8_isr_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_o == PH_HI && ack_rise_o) |=> isr_o[win_q_o]);

  a_r10_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    inta_n |-> (!data_oe && data_o == 8'h00));
endmodule

// File: rtl/irq_call_seq.sv
module irq_call_seq
  import irq_call_pkg::*;
#(
  parameter int NLINES = 8,
  localparam int IDX_W = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] req_i,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              inta_n,
  output logic              int_o,
  output logic [7:0]        data_o,
  output logic              data_oe
);
  logic [NLINES-1:0] mask_q;
  logic [15:0]       base_q;
  logic              wide_q;
  logic              eoi_hit;
  logic [NLINES-1:0] eoi_bits;
  logic [NLINES-1:0] isr_q;
  logic              res_any;
  logic [IDX_W-1:0]  res_win;
  logic [IDX_W-1:0]  win_q;
  ack_ph_t           ph;
  logic              ack_fall;
  logic              ack_rise;

  irq_cfg_regs #(.NLINES(NLINES)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .mask_o(mask_q), .base_o(base_q), .wide_o(wide_q),
    .eoi_o(eoi_hit), .eoi_bits_o(eoi_bits)
  );

  irq_prio_resolver #(.NLINES(NLINES)) u_res (
    .req(req_i), .mask(mask_q), .isr(isr_q), .any_o(res_any), .win_o(res_win)
  );

  irq_ack_fsm #(.NLINES(NLINES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .inta_n(inta_n), .win_in(res_win),
    .eoi(eoi_hit), .eoi_bits(eoi_bits), .base(base_q), .wide(wide_q),
    .ph_o(ph), .ack_fall_o(ack_fall), .ack_rise_o(ack_rise), .win_q_o(win_q),
    .isr_o(isr_q), .data_o(data_o), .data_oe(data_oe)
  );

  assign int_o = res_any && (ph == PH_IDLE);

  a_r1_int_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> |(req_i & ~mask_q));

  a_r1_int_off_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_IDLE) |-> !int_o);

  a_r11_masked_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
    res_any |-> (!mask_q[res_win] && req_i[res_win]));

  a_r8_blocked_below: assert property (@(posedge clk) disable iff (!rst_n)
    res_any |-> ((isr_q & ((NLINES'(2) << res_win) - NLINES'(1))) == '0));

  a_r7_latch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE && ack_fall) |=> (ph == PH_OP));
endmodule

// File: tb/tb_irq_call_seq.sv
module tb_irq_call_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_i = '0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       inta_n = 1'b1;
  logic       int_o;
  logic [7:0] data_o;
  logic       data_oe;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [7:0]  m_mask = 8'hFF;
  logic [15:0] m_base = 16'h0000;
  logic        m_wide = 1'b0;
  logic [7:0]  m_isr  = 8'h00;

  always #5 clk = ~clk;

  irq_call_seq dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .inta_n(inta_n),
    .int_o(int_o), .data_o(data_o), .data_oe(data_oe)
  );

  // Winner per requirements R2, R8, R11, or -1 when none.
  function automatic int exp_line(input logic [7:0] r);
    for (int i = 0; i < 8; i++) begin
      if (m_isr[i]) return -1;
      if (r[i] && !m_mask[i]) return i;
    end
    return -1;
  endfunction

  function automatic logic [15:0] exp_addr(input int line);
    int step;
    step = m_wide ? 8 : 4;
    return 16'(int'(m_base) + line * step);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (a)
      3'd0: m_mask = d;
      3'd1: m_base[7:0] = d;
      3'd2: m_base[15:8] = d;
      3'd3: m_wide = d[0];
      3'd4: m_isr = m_isr & ~d;
      default: ;
    endcase
  endtask

  task automatic pulse(output logic [7:0] b, output logic oe);
    @(negedge clk); inta_n = 1'b0;
    @(negedge clk);
    @(negedge clk); b = data_o; oe = data_oe;
    inta_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Full three-pulse sequence expecting the given line; new_req, if flag set,
  // is applied after the first pulse (R7).
  task automatic run_ack(input int line, input bit swap, input logic [7:0] new_req);
    logic [7:0] b;
    logic oe;
    logic [15:0] a;
    a = exp_addr(line);
    pulse(b, oe);
    check("R3 opcode", {8'h0, b}, 16'h00CD);
    check("R10 oe during pulse", {15'h0, oe}, 16'h0001);
    check("R1 int low in sequence", {15'h0, int_o}, 16'h0000);
    if (swap) req_i = new_req;
    pulse(b, oe);
    check("R4 low byte", {8'h0, b}, {8'h0, a[7:0]});
    pulse(b, oe);
    check("R5 high byte", {8'h0, b}, {8'h0, a[15:8]});
    check("R10 bus quiet", {7'h0, data_oe, data_o}, 16'h0000);
    m_isr[line] = 1'b1;
  endtask

  task automatic check_int(input string tag);
    check(tag, {15'h0, int_o}, {15'h0, exp_line(req_i) >= 0});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    req_i = 8'hFF;
    @(negedge clk);
    check("R11 reset mask blocks int", {15'h0, int_o}, 16'h0000);
    check("R10 reset bus", {7'h0, data_oe, data_o}, 16'h0000);

    // R11: masked line ignored
    wr(3'd0, 8'h01);
    req_i = 8'h01;
    @(negedge clk);
    check("R11 masked only request", {15'h0, int_o}, 16'h0000);
    req_i = 8'h05;
    @(negedge clk);
    check("R11 unmasked request raises int", {15'h0, int_o}, 16'h0001);

    // R2/R6: priority and step 4 with base 0x1200
    wr(3'd1, 8'h00); wr(3'd2, 8'h12);
    run_ack(2, 1'b0, 8'h00);
    // R8: line 2 in service; line 3 blocked, line 1 allowed
    req_i = 8'h0C;
    @(negedge clk);
    check("R8 lower priority blocked", {15'h0, int_o}, 16'h0000);
    req_i = 8'h02;
    wr(3'd0, 8'h00);
    check("R8 higher priority passes", {15'h0, int_o}, 16'h0001);
    // R7: swap to line 0 mid-sequence, still line 1; step 8
    wr(3'd3, 8'h01);
    run_ack(1, 1'b1, 8'h01);
    check("R1 line0 above isr", {15'h0, int_o}, 16'h0001);
    run_ack(0, 1'b0, 8'h00);
    req_i = 8'h80;
    @(negedge clk);
    check("R8 all blocked", {15'h0, int_o}, 16'h0000);
    // R9: selective clear
    wr(3'd4, 8'h03);
    check("R9 isr2 still blocks", {15'h0, int_o}, 16'h0000);
    wr(3'd4, 8'h04);
    check("R9 cleared all", {15'h0, int_o}, 16'h0001);
    run_ack(7, 1'b0, 8'h00);
    check("R6 top base", {15'h0, m_wide}, 16'h0001);
    wr(3'd4, 8'hFF);

    // Random phase
    for (int it = 0; it < 300; it++) begin
      int w;
      if ($urandom_range(0, 3) == 0) wr(3'd0, 8'($urandom & $urandom));
      if ($urandom_range(0, 3) == 0) wr(3'd1, 8'($urandom));
      if ($urandom_range(0, 3) == 0) wr(3'd2, 8'($urandom));
      if ($urandom_range(0, 3) == 0) wr(3'd3, 8'($urandom));
      @(negedge clk);
      req_i = 8'($urandom);
      @(negedge clk);
      check_int("R1 random int");
      w = exp_line(req_i);
      if (w >= 0) run_ack(w, 1'b0, 8'h00);
      if ($urandom_range(0, 1) == 0) begin
        wr(3'd4, 8'($urandom));
        check_int("R9 random eoi");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule